// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a small word-addressed store shared by many hardware threads. Every 64-bit word has a one-bit presence tag that reads as either full or empty. A thread can issue four kinds of access. A plain read and a plain write always complete at once. A read-when-full and a write-when-empty complete only once the word's tag is in the state they need. Conditional accesses that cannot complete are parked inside the memory and retried, so the thread that issued one may wait an unbounded number of cycles for its reply.

Requests arrive on a valid/ready port that carries a thread tag, an operation code, a word address and write data. Replies leave on a response port that carries the issuing thread's tag and a data word. Parked requests sit in a small ordered queue. The queue is re-examined every cycle against the current tags, so a parked access completes in the cycle after the access that changed its word. An initialisation input marks every word empty in one cycle.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset all tags are empty, all data words are zero, the parked queue is empty, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: An accepted plain read (op code 0) replies in the next cycle with the stored word and leaves the tag unchanged.
- R3: An accepted plain write (op code 1) stores the data, marks the word full, and replies in the next cycle with the written data.
- R4: An accepted read-when-full (op code 2) on a full word, with no parked request to that address, replies in the next cycle with the stored word and marks the word empty.
- R5: An accepted write-when-empty (op code 3) on an empty word, with no parked request to that address, stores the data, marks the word full and replies in the next cycle with the written data.
- R6: A conditional request whose tag condition fails, or whose address already has a parked request, produces no reply and is parked. It is later served with the tag of the thread that issued it, and the queue never holds more than 8 entries.
- R7: At most one parked request is served per cycle. It is the oldest entry whose condition holds and which has no older parked entry to the same address, so requests to one address complete in arrival order.
- R8: `req_ready_o` is low in any cycle in which the queue holds 8 entries, a parked request is being served, or `init_i` is high.
- R9: While `init_i` is high, every tag is cleared to empty, data words are kept, and no parked request is served.
- R10: Each served request yields exactly one reply, with `rsp_valid_o` high for the single cycle after the serving clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Clear all presence tags to empty |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_tid_i | input | TID_W | Issuing thread tag |
| req_op_i | input | 2 | 0 read, 1 write, 2 read-when-full, 3 write-when-empty |
| req_addr_i | input | ADDR_W | Word address |
| req_data_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Reply present for one cycle |
| rsp_tid_o | output | TID_W | Thread tag of the served request |
| rsp_data_o | output | DATA_W | Read data, or the written data for writes |

## Verification
The bench aims at collisions on a handful of addresses. One case is a write-when-empty queued behind a parked read-when-full on the same word: a design that ignored arrival order would let the write overtake the read and return the wrong data to both threads. A plain write must release parked readers in the next cycle, and an initialisation pulse must leave data intact while parking later reads. A fully parked queue must drop ready; a design that miscounted would either overwrite an entry or stall early, and the cycle-accurate model in the bench flags both as a ready or reply mismatch.

// File: rtl/fe_sync_pkg.sv
// Package: operation codes and tag-condition helpers shared by the
// synchronizing memory and its submodules. Assumes a one-bit tag, 1 = full.
package fe_sync_pkg;

    typedef enum logic [1:0] {
        OP_READ        = 2'd0,
        OP_WRITE       = 2'd1,
        OP_READ_FULL   = 2'd2,
        OP_WRITE_EMPTY = 2'd3
    } mem_op_e;

    // True when the operation may complete given the word's tag.
    function automatic logic op_ready(input mem_op_e op, input logic tag);
        case (op)
            OP_READ_FULL:   return tag;
            OP_WRITE_EMPTY: return !tag;
            default:        return 1'b1;
        endcase
    endfunction

    // True for operations that store data.
    function automatic logic op_is_write(input mem_op_e op);
        return (op == OP_WRITE) || (op == OP_WRITE_EMPTY);
    endfunction

    // True for operations that wait on the tag.
    function automatic logic op_is_cond(input mem_op_e op);
        return (op == OP_READ_FULL) || (op == OP_WRITE_EMPTY);
    endfunction

endpackage

// File: rtl/fe_word_store.sv
// Word store: data words plus one presence tag per word, single access port.
// Assumes the caller never writes in a cycle where init_i is high.
module fe_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   init_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   data_we_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic                   tag_we_i,
    input  logic                   tag_val_i,
    output logic [DATA_W-1:0]      rdata_o,
    output logic [(1<<ADDR_W)-1:0] tags_o
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [WORDS-1:0]  tags_q;

    // Data array: cleared on reset, written on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (data_we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    // Tag array: emptied on reset or init, updated on request.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) tags_q <= '0;
        else if (tag_we_i)    tags_q[addr_i] <= tag_val_i;
    end

    assign rdata_o = mem_q[addr_i];
    assign tags_o  = tags_q;

endmodule

// File: rtl/fe_pend_queue.sv
// Parked-request queue: compacting list kept in arrival order (entry 0 oldest).
// Selects the oldest entry whose tag condition holds and that has no older
// entry to the same address. Assumes push and pop never coincide and that
// push only happens when not full.
module fe_pend_queue
    import fe_sync_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 64,
    parameter int TID_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_i,
    input  mem_op_e                 push_op_i,
    input  logic [ADDR_W-1:0]       push_addr_i,
    input  logic [DATA_W-1:0]       push_data_i,
    input  logic [TID_W-1:0]        push_tid_i,
    input  logic                    pop_i,
    input  logic [(1<<ADDR_W)-1:0]  tags_i,
    input  logic [ADDR_W-1:0]       probe_addr_i,
    output logic                    probe_hit_o,
    output logic                    any_o,
    output mem_op_e                 sel_op_o,
    output logic [ADDR_W-1:0]       sel_addr_o,
    output logic [DATA_W-1:0]       sel_data_o,
    output logic [TID_W-1:0]        sel_tid_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    mem_op_e           e_op   [DEPTH];
    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];
    logic [TID_W-1:0]  e_tid  [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic              elig   [DEPTH];
    logic [IDX_W-1:0]  sel;

    // Per-entry eligibility: valid, head of its address, condition met.
    for (genvar g = 0; g < DEPTH; g++) begin : g_elig
        logic older;
        always_comb begin
            older = 1'b0;
            for (int j = 0; j < g; j++)
                if (e_addr[j] == e_addr[g]) older = 1'b1;
            elig[g] = (CNT_W'(g) < cnt_q) && !older &&
                      op_ready(e_op[g], tags_i[e_addr[g]]);
        end
    end

    // Lowest-index eligible entry wins.
    always_comb begin
        any_o = 1'b0;
        sel   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any_o = 1'b1;
                sel   = IDX_W'(i);
            end
        end
    end

    // Any valid entry already waiting on the probed address.
    always_comb begin
        probe_hit_o = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if ((CNT_W'(i) < cnt_q) && (e_addr[i] == probe_addr_i))
                probe_hit_o = 1'b1;
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (pop_i)  cnt_q <= cnt_q - 1'b1;
        else if (push_i) cnt_q <= cnt_q + 1'b1;
    end

    // Entry storage: close the gap on pop, append on push.
    always_ff @(posedge clk) begin
        if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= sel) begin
                    e_op[i]   <= e_op[i+1];
                    e_addr[i] <= e_addr[i+1];
                    e_data[i] <= e_data[i+1];
                    e_tid[i]  <= e_tid[i+1];
                end
            end
        end else if (push_i) begin
            e_op[cnt_q[IDX_W-1:0]]   <= push_op_i;
            e_addr[cnt_q[IDX_W-1:0]] <= push_addr_i;
            e_data[cnt_q[IDX_W-1:0]] <= push_data_i;
            e_tid[cnt_q[IDX_W-1:0]]  <= push_tid_i;
        end
    end

    assign sel_op_o   = e_op[sel];
    assign sel_addr_o = e_addr[sel];
    assign sel_data_o = e_data[sel];
    assign sel_tid_o  = e_tid[sel];
    assign cnt_o      = cnt_q;

endmodule

// File: rtl/fe_sync_mem.sv
// Top: full/empty tagged memory. Each cycle it serves either one parked
// request (priority) or one new request. New conditional requests that
// cannot complete, or that target an address already parked, are queued.
// Replies are registered: one cycle after the serving edge.
module fe_sync_mem
    import fe_sync_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 4,
    parameter int TID_W  = 4,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [TID_W-1:0]  req_tid_i,
    input  logic [1:0]        req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_data_i,
    output logic              rsp_valid_o,
    output logic [TID_W-1:0]  rsp_tid_o,
    output logic [DATA_W-1:0] rsp_data_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int WORDS = 1 << ADDR_W;

    mem_op_e           req_op;
    logic              q_any, q_hit;
    mem_op_e           q_op;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_data;
    logic [TID_W-1:0]  q_tid;
    logic [CNT_W-1:0]  q_cnt;
    logic [WORDS-1:0]  tags;
    logic [DATA_W-1:0] rdata;

    logic              retry_go, accept, park, exec;
    mem_op_e           acc_op;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_data;
    logic [TID_W-1:0]  acc_tid;

    assign req_op = mem_op_e'(req_op_i);

    // Admission and serve control.
    always_comb begin
        retry_go    = q_any && !init_i;
        req_ready_o = !init_i && !q_any && (q_cnt != CNT_W'(DEPTH));
        accept      = req_valid_i && req_ready_o;
        park        = accept && op_is_cond(req_op) &&
                      (q_hit || !op_ready(req_op, tags[req_addr_i]));
        exec        = retry_go || (accept && !park);
    end

    // Access source select: parked entry has priority.
    always_comb begin
        if (retry_go) begin
            acc_op = q_op;   acc_addr = q_addr;
            acc_data = q_data; acc_tid = q_tid;
        end else begin
            acc_op = req_op;   acc_addr = req_addr_i;
            acc_data = req_data_i; acc_tid = req_tid_i;
        end
    end

    fe_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .addr_i    (acc_addr),
        .data_we_i (exec && op_is_write(acc_op)),
        .wdata_i   (acc_data),
        .tag_we_i  (exec && (acc_op != OP_READ)),
        .tag_val_i (op_is_write(acc_op)),
        .rdata_o   (rdata),
        .tags_o    (tags)
    );

    fe_pend_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W)) queue_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (park),
        .push_op_i    (req_op),
        .push_addr_i  (req_addr_i),
        .push_data_i  (req_data_i),
        .push_tid_i   (req_tid_i),
        .pop_i        (retry_go),
        .tags_i       (tags),
        .probe_addr_i (req_addr_i),
        .probe_hit_o  (q_hit),
        .any_o        (q_any),
        .sel_op_o     (q_op),
        .sel_addr_o   (q_addr),
        .sel_data_o   (q_data),
        .sel_tid_o    (q_tid),
        .cnt_o        (q_cnt)
    );

    // Reply register: one pulse per served request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_tid_o   <= '0;
            rsp_data_o  <= '0;
        end else begin
            rsp_valid_o <= exec;
            if (exec) begin
                rsp_tid_o  <= acc_tid;
                rsp_data_o <= op_is_write(acc_op) ? acc_data : rdata;
            end
        end
    end

endmodule

// File: rtl/fe_sync_mem_chk.sv
// Checker: port-level and occupancy properties of the tagged memory,
// attached to every instance of the top through bind.
module fe_sync_mem_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 4,
    parameter int TID_W  = 4,
    parameter int DEPTH  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      init_i,
    input logic                      req_valid_i,
    input logic                      req_ready_o,
    input logic [TID_W-1:0]          req_tid_i,
    input logic [1:0]                req_op_i,
    input logic [DATA_W-1:0]         req_data_i,
    input logic                      rsp_valid_o,
    input logic [TID_W-1:0]          rsp_tid_o,
    input logic [DATA_W-1:0]         rsp_data_o,
    input logic [$clog2(DEPTH+1)-1:0] pend_cnt
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt == CNT_W'(DEPTH)) |-> !req_ready_o); // R8
    AST_INIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |-> !req_ready_o); // R8
    AST_PLAIN_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !req_op_i[1]) |=> (rsp_valid_o && rsp_tid_o == $past(req_tid_i))); // R10
    AST_WRITE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && req_op_i == 2'd1) |=> (rsp_data_o == $past(req_data_i))); // R3
    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= CNT_W'(DEPTH)); // R6

endmodule

bind fe_sync_mem fe_sync_mem_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TID_W(TID_W), .DEPTH(DEPTH)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_tid_i   (req_tid_i),
    .req_op_i    (req_op_i),
    .req_data_i  (req_data_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_tid_o   (rsp_tid_o),
    .rsp_data_o  (rsp_data_o),
    .pend_cnt    (q_cnt)
);

// File: tb/fe_sync_mem_tb_top.sv
// Bench: cycle model of the requirements drives directed and random traffic
// and compares ready and replies every cycle.
`timescale 1ns/1ps
module fe_sync_mem_tb_top;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 4;
    localparam int TID_W  = 4;
    localparam int DEPTH  = 8;
    localparam int WORDS  = 1 << ADDR_W;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0, init_i = 1'b0, req_valid = 1'b0, req_ready;
    logic [TID_W-1:0]  req_tid = '0;
    logic [1:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              rsp_valid;
    logic [TID_W-1:0]  rsp_tid;
    logic [DATA_W-1:0] rsp_data;

    fe_sync_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TID_W(TID_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_i(init_i),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_tid_i(req_tid),
        .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
        .rsp_valid_o(rsp_valid), .rsp_tid_o(rsp_tid), .rsp_data_o(rsp_data)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    bit                m_tag  [WORDS];
    logic [DATA_W-1:0] m_mem  [WORDS];
    logic [1:0]        q_op   [DEPTH];
    logic [ADDR_W-1:0] q_addr [DEPTH];
    logic [DATA_W-1:0] q_data [DEPTH];
    logic [TID_W-1:0]  q_tid  [DEPTH];
    int                q_cnt = 0;
    bit                e_valid = 1'b0;
    logic [TID_W-1:0]  e_tid = '0;
    logic [DATA_W-1:0] e_data = '0;
    string             e_req = "R1";

    function automatic bit cond_ok(logic [1:0] op, bit tag);
        if (op == 2'd2) return tag;
        if (op == 2'd3) return !tag;
        return 1'b1;
    endfunction

    function automatic int pick();
        for (int i = 0; i < q_cnt; i++) begin
            bit older = 1'b0;
            for (int j = 0; j < i; j++) if (q_addr[j] == q_addr[i]) older = 1'b1;
            if (!older && cond_ok(q_op[i], m_tag[q_addr[i]])) return i;
        end
        return -1;
    endfunction

    function automatic bit addr_parked(logic [ADDR_W-1:0] a);
        for (int i = 0; i < q_cnt; i++) if (q_addr[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(bit ok, string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_exec(logic [1:0] op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic [TID_W-1:0] t);
        e_valid = 1'b1;
        e_tid   = t;
        e_data  = op[0] ? d : m_mem[a];
        if (op[0]) m_mem[a] = d;
        if (op != 2'd0) m_tag[a] = op[0];
    endtask

    task automatic model_clear();
        for (int i = 0; i < WORDS; i++) begin m_tag[i] = 1'b0; m_mem[i] = '0; end
        q_cnt = 0; e_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0; init_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        e_req = "R1";
    endtask

    // One cycle: compare last reply, drive, compare ready, advance model.
    task automatic step(bit v, logic [1:0] op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                        logic [TID_W-1:0] t, bit ini, string req);
        int  sel;
        bit  exp_rdy;
        check(rsp_valid == e_valid, e_req, "rsp_valid (R10)", 64'(rsp_valid), 64'(e_valid));
        if (e_valid) begin
            check(rsp_tid == e_tid, e_req, "rsp_tid", 64'(rsp_tid), 64'(e_tid));
            check(rsp_data == e_data, e_req, "rsp_data", rsp_data, e_data);
        end
        sel = pick();
        exp_rdy = !ini && (q_cnt < DEPTH) && (sel < 0);
        init_i = ini; req_valid = v; req_op = op; req_addr = a; req_data = d; req_tid = t;
        #1;
        check(req_ready == exp_rdy, req, "req_ready (R8)", 64'(req_ready), 64'(exp_rdy));
        e_valid = 1'b0;
        e_req = req;
        if (ini) begin
            for (int i = 0; i < WORDS; i++) m_tag[i] = 1'b0;
        end else if (sel >= 0) begin
            model_exec(q_op[sel], q_addr[sel], q_data[sel], q_tid[sel]);
            for (int k = sel; k < q_cnt - 1; k++) begin
                q_op[k] = q_op[k+1]; q_addr[k] = q_addr[k+1];
                q_data[k] = q_data[k+1]; q_tid[k] = q_tid[k+1];
            end
            q_cnt--;
        end else if (v && exp_rdy) begin
            if (op[1] && (addr_parked(a) || !cond_ok(op, m_tag[a]))) begin
                q_op[q_cnt] = op; q_addr[q_cnt] = a; q_data[q_cnt] = d; q_tid[q_cnt] = t;
                q_cnt++;
            end else begin
                model_exec(op, a, d, t);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(string req);
        step(1'b0, 2'd0, '0, '0, '0, 1'b0, req);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        do_reset();
        // R1: reset state and zeroed data
        idle("R1");
        step(1'b1, 2'd0, 4'd5, '0, 4'd1, 1'b0, "R1");
        // R3, R2: plain write then read
        step(1'b1, 2'd1, 4'd2, 64'hA5A5_0000_1111_2222, 4'd3, 1'b0, "R3");
        step(1'b1, 2'd0, 4'd2, '0, 4'd8, 1'b0, "R2");
        // R4: read-when-full empties; second one parks (R6)
        step(1'b1, 2'd2, 4'd2, '0, 4'd4, 1'b0, "R4");
        step(1'b1, 2'd2, 4'd2, '0, 4'd5, 1'b0, "R6");
        // R7: write-when-empty on empty word must queue behind the parked read
        step(1'b1, 2'd3, 4'd2, 64'hBBBB_BBBB_0000_0001, 4'd6, 1'b0, "R7");
        idle("R7");
        // plain write releases reader, then parked writer follows
        step(1'b1, 2'd1, 4'd2, 64'hCCCC_0000_CCCC_0000, 4'd7, 1'b0, "R6");
        idle("R7");
        idle("R7");
        idle("R7");
        step(1'b1, 2'd0, 4'd2, '0, 4'd9, 1'b0, "R7");
        // R5: write-when-empty on empty word completes at once
        step(1'b1, 2'd3, 4'd6, 64'h6666_0000_0000_6666, 4'd2, 1'b0, "R5");
        step(1'b1, 2'd0, 4'd6, '0, 4'd2, 1'b0, "R5");
        // R9: init empties tags, keeps data; a read-when-full then parks
        step(1'b1, 2'd0, 4'd6, '0, 4'd1, 1'b1, "R9");
        step(1'b1, 2'd0, 4'd6, '0, 4'd1, 1'b0, "R9");
        step(1'b1, 2'd2, 4'd6, '0, 4'd3, 1'b0, "R9");
        idle("R9");
        step(1'b1, 2'd1, 4'd6, 64'h0123_4567_89AB_CDEF, 4'd4, 1'b0, "R9");
        idle("R9");
        idle("R9");
        // R8: fill the queue with read-when-full on empty words
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 2'd2, 4'(9 + (i % 3)), '0, 4'(i), 1'b0, "R8");
        step(1'b1, 2'd1, 4'd9, 64'h1, 4'd0, 1'b0, "R8");
        idle("R8");
        do_reset();
        idle("R1");
        // Random traffic on four addresses
        for (int n = 0; n < 4000; n++) begin
            if (q_cnt == DEPTH && pick() < 0) begin
                do_reset();
                idle("R1");
            end
            step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 3)),
                 {$urandom, $urandom}, 4'($urandom_range(0, 15)),
                 $urandom_range(0, 63) == 0, "R7");
        end
        idle("R10");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule